// File: doc/BRIEF.md
# Four-Channel SPI Master Transfer Sequencer

This block decides, for each of four SPI master channels, when a word moves from the channel's transmit holding register through one shared serial shifter and into the channel's receive holding register. Each channel has a configuration word, a three-flag status word and an enable bit. These are reached through a simple register port with one-cycle write and read strobes. The address carries the channel number in its upper bits and a two-bit register selector in its lower bits. Selector 0 is configuration and selector 1 is status, which is read-only. Selector 2 is the enable bit. Selector 3 writes the transmit holding register and reads the receive holding register. Each channel drives one transmit and one receive DMA request line, plus a flag that marks an illegal configuration.

Register writes and receive reads raise a per-channel pending attempt. When the shifter is free, the lowest-numbered pending channel is granted. Its attempt is evaluated against the enable bit, the transfer mode, the turbo bit and the status flags. A granted attempt either shifts a word on the wire or, in single-channel mode without the force bit, finishes without touching the wire. The shifter state machine has four states. In IDLE, a grant that will exchange data goes to LEAD, and a grant that finishes silently goes to FINISH. LEAD holds SCLK low for the divider period, samples MISO and moves to TRAIL. TRAIL holds SCLK high, then returns to LEAD if bits remain or goes to FINISH after the last bit. FINISH updates the channel flags and returns to IDLE.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: After reset every channel reads configuration 0x060000, status 3'b010 (only transmit-empty set) and enable 0. All DMA requests are low and all chip selects are high.
- R2: A configuration write keeps bits [22:0] and reads back with bits [31:23] zero. cfg_bad is high when the mode field [13:12] equals 3 or the length field [11:7] is below 3.
- R3: A completed attempt clears the transmit holding register and sets status bit 2 (end-of-transfer) and bit 1 (transmit-empty). It sets bit 0 (receive-full) unless the mode is 2, which is transmit-only.
- R4: An exchange shifts (field [11:7] + 1) bits, MSB first. MOSI changes on falling SCLK and MISO is sampled on rising SCLK. The received bits are right-aligned in the receive register, and only the granted channel's chip select is low.
- R5: While a channel is disabled, an attempt does nothing. A control write that takes enable from 0 to 1 starts an attempt; any other control write only loads bit 0.
- R6: When receive-full is set, the mode is not 2 and turbo (bit 19) is clear, an attempt stalls. A receive read returns the held word, clears receive-full and starts a new attempt.
- R7: With turbo set, a transfer proceeds while receive-full is set.
- R8: With single-channel mode on and force (bit 20) clear, an attempt updates status without touching the wire and leaves the receive register unchanged. With force set, the word is exchanged.
- R9: tx_dreq is enable AND bit 14 AND transmit-empty AND mode != 1. rx_dreq is enable AND bit 15 AND receive-full AND mode != 2.
- R10: At most one chip select is low at a time, and pending channels are granted lowest number first.
- R11: In mode 1 (receive-only), a set transmit-empty flag does not stall an attempt, so enabling the channel or reading its receive register starts a reception without a transmit write.
- R12: An attempt raised while the shifter is busy is held and evaluated after the current word finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| solo_mode | input | 1 | Single-channel mode: exchange only when force is set |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | {channel, selector} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects, one per channel |
| tx_dreq | output | 4 | Transmit DMA requests |
| rx_dreq | output | 4 | Receive DMA requests |
| cfg_bad | output | 4 | Illegal configuration flags |

## Verification
The hardest situations to reach are the ones where several attempts are queued at once: the ascending grant order and the hold-off of a same-channel attempt during a shift. The bench gets there by starting one channel's transfer. Inside the few dozen cycles the word takes to shift, it writes two other channels or reads the busy channel's receive register, then checks the order and count of chip-select falls. A slave model on the serial pins returns a chosen word and records the bits it sees, so the bit order and the word length are checked from the wire.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;
    localparam int WORD_W   = 32;
    localparam int CFG_W    = 23;
    localparam int ST_W     = 3;
    localparam int LEN_W    = 6;
    localparam int MODE_LO  = 12;
    localparam int LEN_LO   = 7;
    localparam int DTX_BIT  = 14;
    localparam int DRX_BIT  = 15;
    localparam int TURBO_B  = 19;
    localparam int FORCE_B  = 20;
    localparam int ST_RXF   = 0;
    localparam int ST_TXE   = 1;
    localparam int ST_EOT   = 2;
    localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;

    typedef enum logic [1:0] {
        XM_BOTH   = 2'd0,
        XM_RXONLY = 2'd1,
        XM_TXONLY = 2'd2,
        XM_BAD    = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        E_IDLE, E_LEAD, E_TRAIL, E_FINISH
    } eng_state_e;
endpackage

// File: rtl/spi_chan_regs.sv
`timescale 1ns/1ps
module spi_chan_regs
    import spi_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              ctl_we,
    input  logic              tx_we,
    input  logic              rx_re,
    input  logic [WORD_W-1:0] wdata,
    input  logic              done,
    input  logic              rx_load,
    input  logic [WORD_W-1:0] rx_word,
    output logic [CFG_W-1:0]  cfg,
    output logic              en,
    output logic [ST_W-1:0]   stat,
    output logic [WORD_W-1:0] tx,
    output logic [WORD_W-1:0] rx,
    output logic              trig,
    output logic              tx_dreq,
    output logic              rx_dreq,
    output logic              cfg_bad
);
    xfer_mode_e mode;
    assign mode = xfer_mode_e'(cfg[MODE_LO+1:MODE_LO]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg  <= CFG_RST;
            en   <= 1'b0;
            stat <= 3'b010;
            tx   <= '0;
            rx   <= '0;
        end else begin
            if (cfg_we) cfg <= wdata[CFG_W-1:0];
            if (ctl_we) en <= wdata[0];
            if (tx_we) begin
                tx           <= wdata;
                stat[ST_TXE] <= 1'b0;
            end
            if (rx_re) stat[ST_RXF] <= 1'b0;
            if (done) begin
                tx           <= '0;
                stat[ST_EOT] <= 1'b1;
                stat[ST_TXE] <= 1'b1;
                if (mode != XM_TXONLY) stat[ST_RXF] <= 1'b1;
                if (rx_load) rx <= rx_word;
            end
        end
    end

    always_comb begin
        trig    = tx_we | rx_re | (ctl_we & wdata[0] & ~en);
        tx_dreq = en & cfg[DTX_BIT] & stat[ST_TXE] & (mode != XM_RXONLY);
        rx_dreq = en & cfg[DRX_BIT] & stat[ST_RXF] & (mode != XM_TXONLY);
        cfg_bad = (mode == XM_BAD) | (cfg[LEN_LO+4:LEN_LO] < 5'd3);
    end

    // R3: completion leaves end-of-transfer and transmit-empty set
    p_done_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (stat[ST_EOT] && stat[ST_TXE]));

    // R6: a receive read without a completing word clears receive-full
    p_rx_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_re && !done) |=> !stat[ST_RXF]);
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
    import spi_xfer_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_shift,
    input  logic [((NCH>1)?$clog2(NCH):1)-1:0] go_ch,
    input  logic [WORD_W-1:0] go_tx,
    input  logic [LEN_W-1:0]  go_len,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [((NCH>1)?$clog2(NCH):1)-1:0] done_ch,
    output logic              rx_load,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic [NCH-1:0]    cs_n
);
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    eng_state_e          state, state_nx;
    logic [CH_W-1:0]     cur_ch;
    logic                shifted;
    logic [WORD_W-1:0]   sh_tx, sh_rx;
    logic [LEN_W-1:0]    bits_left;
    logic [DIV_W-1:0]    div_cnt;
    logic                tick, on_wire;

    assign tick = (div_cnt == DIV_W'(CLK_DIV - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            E_IDLE:   if (go) state_nx = go_shift ? E_LEAD : E_FINISH;
            E_LEAD:   if (tick) state_nx = E_TRAIL;
            E_TRAIL:  if (tick) state_nx = (bits_left == LEN_W'(1)) ? E_FINISH : E_LEAD;
            E_FINISH: state_nx = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= E_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch    <= '0;
            shifted   <= 1'b0;
            sh_tx     <= '0;
            sh_rx     <= '0;
            bits_left <= '0;
            div_cnt   <= '0;
        end else if (state == E_IDLE) begin
            if (go) begin
                cur_ch    <= go_ch;
                shifted   <= go_shift;
                sh_tx     <= go_tx << (LEN_W'(WORD_W) - go_len);
                sh_rx     <= '0;
                bits_left <= go_len;
                div_cnt   <= '0;
            end
        end else if (state == E_LEAD || state == E_TRAIL) begin
            div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
            if (tick && state == E_LEAD) sh_rx <= {sh_rx[WORD_W-2:0], miso};
            if (tick && state == E_TRAIL) begin
                sh_tx     <= sh_tx << 1;
                bits_left <= bits_left - LEN_W'(1);
            end
        end
    end

    always_comb begin
        on_wire = (state == E_LEAD) || (state == E_TRAIL);
        busy    = (state != E_IDLE);
        done    = (state == E_FINISH);
        done_ch = cur_ch;
        rx_load = done & shifted;
        rx_word = sh_rx;
        sclk    = (state == E_TRAIL);
        mosi    = on_wire & sh_tx[WORD_W-1];
        for (int k = 0; k < NCH; k++)
            cs_n[k] = !(on_wire && cur_ch == CH_W'(k));
    end

    // R10: never more than one device selected
    p_one_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R12: the sequencer only grants while the shifter is free
    p_go_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (state == E_IDLE));

    // R4: serial clock pulses only inside a selected frame
    p_sclk_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !(&cs_n));
endmodule

// File: rtl/spi_xfer_ctrl.sv
`timescale 1ns/1ps
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CLK_DIV = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 solo_mode,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [((NCH>1)?$clog2(NCH):1)+1:0] reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 spi_sclk,
    output logic                 spi_mosi,
    input  logic                 spi_miso,
    output logic [NCH-1:0]       spi_cs_n,
    output logic [NCH-1:0]       tx_dreq,
    output logic [NCH-1:0]       rx_dreq,
    output logic [NCH-1:0]       cfg_bad
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CFG_W-1:0]  cfg_a  [NCH];
    logic [ST_W-1:0]   stat_a [NCH];
    logic [WORD_W-1:0] tx_a   [NCH];
    logic [WORD_W-1:0] rx_a   [NCH];
    logic [NCH-1:0]    en_a, trig_a, pend;
    logic [1:0]        sel;
    logic [CH_W-1:0]   acc_ch, pick, done_ch;
    logic              any_pend, go, go_shift, busy, done, rx_load, ok;
    logic              rx_stall, tx_stall;
    logic [LEN_W-1:0]  go_len;
    logic [WORD_W-1:0] rx_word;
    xfer_mode_e        pmode;

    assign sel    = reg_addr[1:0];
    assign acc_ch = reg_addr[CH_W+1:2];

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic hit;
        assign hit = (acc_ch == CH_W'(k));
        spi_chan_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (reg_wr & hit & (sel == 2'd0)),
            .ctl_we  (reg_wr & hit & (sel == 2'd2)),
            .tx_we   (reg_wr & hit & (sel == 2'd3)),
            .rx_re   (reg_rd & hit & (sel == 2'd3)),
            .wdata   (reg_wdata),
            .done    (done & (done_ch == CH_W'(k))),
            .rx_load (rx_load),
            .rx_word (rx_word),
            .cfg     (cfg_a[k]),
            .en      (en_a[k]),
            .stat    (stat_a[k]),
            .tx      (tx_a[k]),
            .rx      (rx_a[k]),
            .trig    (trig_a[k]),
            .tx_dreq (tx_dreq[k]),
            .rx_dreq (rx_dreq[k]),
            .cfg_bad (cfg_bad[k])
        );
    end

    always_comb begin
        pick     = '0;
        any_pend = 1'b0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (pend[k]) begin
                pick     = CH_W'(k);
                any_pend = 1'b1;
            end
        end
        pmode    = xfer_mode_e'(cfg_a[pick][MODE_LO+1:MODE_LO]);
        rx_stall = stat_a[pick][ST_RXF] && (pmode != XM_TXONLY) && !cfg_a[pick][TURBO_B];
        tx_stall = stat_a[pick][ST_TXE] && (pmode != XM_RXONLY);
        ok       = en_a[pick] && !rx_stall && !tx_stall;
        go       = !busy && any_pend && ok;
        go_shift = !solo_mode || cfg_a[pick][FORCE_B];
        go_len   = {1'b0, cfg_a[pick][LEN_LO+4:LEN_LO]} + LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else if (!busy && any_pend)
            pend <= (pend & ~(NCH'(1) << pick)) | trig_a;
        else
            pend <= pend | trig_a;
    end

    spi_shift_engine #(.NCH(NCH), .CLK_DIV(CLK_DIV)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_shift (go_shift),
        .go_ch    (pick),
        .go_tx    (tx_a[pick]),
        .go_len   (go_len),
        .miso     (spi_miso),
        .busy     (busy),
        .done     (done),
        .done_ch  (done_ch),
        .rx_load  (rx_load),
        .rx_word  (rx_word),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n)
    );

    always_comb begin
        unique case (sel)
            2'd0: reg_rdata = {{(32-CFG_W){1'b0}}, cfg_a[acc_ch]};
            2'd1: reg_rdata = {{(32-ST_W){1'b0}}, stat_a[acc_ch]};
            2'd2: reg_rdata = {31'b0, en_a[acc_ch]};
            2'd3: reg_rdata = rx_a[acc_ch];
        endcase
    end
endmodule

// File: tb/test_spi_xfer_ctrl.sv
`timescale 1ns/1ps
module test_spi_xfer_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        solo = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        sclk, mosi, miso = 1'b0;
    logic [3:0]  cs_n, txd, rxd, bad;
    logic        cs_all;

    int n_chk = 0, n_bad = 0;
    int log_ch [16];
    int log_n = 0;
    int sl_idx = 0, sl_bits = 0, sl_len = 8;
    logic [31:0] sl_word = '0, sl_cap = '0;

    always #10 clk = ~clk;

    spi_xfer_ctrl i_spi_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .solo_mode(solo), .reg_wr(wr), .reg_rd(rd),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n),
        .tx_dreq(txd), .rx_dreq(rxd), .cfg_bad(bad));

    assign cs_all = &cs_n;

    always @(negedge cs_all) begin
        for (int k = 0; k < 4; k++)
            if (!cs_n[k] && log_n < 16) log_ch[log_n] = k;
        log_n   = log_n + 1;
        sl_idx  = sl_len - 1;
        miso    = sl_word[sl_idx];
        sl_cap  = '0;
        sl_bits = 0;
    end
    always @(posedge sclk) begin
        sl_cap  = {sl_cap[30:0], mosi};
        sl_bits = sl_bits + 1;
    end
    always @(negedge sclk) begin
        if (sl_idx > 0) begin
            sl_idx = sl_idx - 1;
            miso   = sl_word[sl_idx];
        end
    end

    typedef struct packed {
        logic [1:0]  mode;
        logic [4:0]  lenf;
        logic        turbo;
        logic        force_b;
        logic        solo_b;
        logic [31:0] tx;
        logic [31:0] miso_w;
        logic [31:0] exp_rx;
        logic [2:0]  exp_st;
        logic [5:0]  exp_bits;
    } vec_t;

    localparam vec_t [0:5] VECS = '{
        '{2'd0, 5'd7,  1'b0, 1'b0, 1'b0, 32'h000000A5, 32'h0000003C, 32'h0000003C, 3'b111, 6'd8},
        '{2'd0, 5'd31, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF, 32'h12345678, 32'h12345678, 3'b111, 6'd32},
        '{2'd2, 5'd11, 1'b0, 1'b0, 1'b0, 32'h00000ABC, 32'h000005A5, 32'h000005A5, 3'b110, 6'd12},
        '{2'd1, 5'd15, 1'b0, 1'b0, 1'b0, 32'h00001234, 32'h0000BEEF, 32'h0000BEEF, 3'b111, 6'd16},
        '{2'd0, 5'd7,  1'b0, 1'b0, 1'b1, 32'h00000055, 32'h000000FF, 32'h00000000, 3'b111, 6'd0},
        '{2'd0, 5'd4,  1'b0, 1'b1, 1'b1, 32'h00000013, 32'h0000000A, 32'h0000000A, 3'b111, 6'd5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        addr = 4'(ch * 4 + sel); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input int ch, input int sel, output logic [31:0] d);
        @(negedge clk);
        addr = 4'(ch * 4 + sel); rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; solo = 1'b0;
        wait_cyc(3);
        log_n = 0; sl_bits = 0; sl_cap = '0;
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    function automatic logic [31:0] cfgw(input int mode, input int lenf, input bit turbo, input bit frc);
        return (32'(frc) << 20) | (32'(turbo) << 19) | (32'(mode) << 12) | (32'(lenf) << 7);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d, mask;
        int base;
        vec_t v;

        // vector walk: R3, R4, R8, R11 per row
        for (int i = 0; i < 6; i++) begin
            v = VECS[i];
            do_reset();
            solo    = v.solo_b;
            sl_word = v.miso_w;
            sl_len  = int'(v.lenf) + 1;
            wr_reg(0, 0, cfgw(v.mode, v.lenf, v.turbo, v.force_b));
            wr_reg(0, 3, v.tx);
            wr_reg(0, 2, 32'd1);
            wait_cyc(160);
            rd_reg(0, 1, d);
            chk("R3 status after transfer", d, {29'b0, v.exp_st});
            chk("R8 frame count", 32'(log_n), (v.exp_bits != 0) ? 32'd1 : 32'd0);
            if (v.exp_bits != 0) begin
                mask = (v.exp_bits == 6'd32) ? 32'hFFFFFFFF : ((32'd1 << v.exp_bits) - 32'd1);
                chk("R4 bit count", 32'(sl_bits), 32'(v.exp_bits));
                chk("R4 MOSI word", sl_cap & mask, v.tx & mask);
            end
            rd_reg(0, 3, d);
            chk("R4 received word", d, v.exp_rx);
        end

        // R1 reset state
        do_reset();
        rd_reg(0, 0, d); chk("R1 config reset", d, 32'h00060000);
        rd_reg(3, 1, d); chk("R1 status reset", d, 32'd2);
        rd_reg(2, 2, d); chk("R1 enable reset", d, 32'd0);
        chk("R1 dma and select idle", {24'b0, txd, rxd}, 32'h0);
        chk("R1 chip selects", {28'b0, cs_n}, 32'hF);

        // R2 config masking and illegal flag
        wr_reg(1, 0, 32'hFFFFFFFF);
        rd_reg(1, 0, d); chk("R2 config mask", d, 32'h007FFFFF);
        chk("R2 bad mode 3", {31'b0, bad[1]}, 32'd1);
        wr_reg(1, 0, cfgw(0, 2, 0, 0));
        chk("R2 bad length 2", {31'b0, bad[1]}, 32'd1);
        wr_reg(1, 0, cfgw(0, 3, 0, 0));
        chk("R2 legal length 3", {31'b0, bad[1]}, 32'd0);

        // R5 disabled channel ignores attempts, enable starts one
        do_reset();
        sl_len = 8; sl_word = 32'h5C;
        wr_reg(0, 0, cfgw(0, 7, 0, 0));
        wr_reg(0, 3, 32'h77);
        wait_cyc(60);
        rd_reg(0, 1, d); chk("R5 disabled status", d, 32'd0);
        chk("R5 disabled no frame", 32'(log_n), 32'd0);
        wr_reg(0, 2, 32'd1);
        wait_cyc(60);
        rd_reg(0, 1, d); chk("R5 enable rising starts", d, 32'd7);
        chk("R5 one frame", 32'(log_n), 32'd1);

        // R6 stall on receive-full, receive read retries
        wr_reg(0, 3, 32'h11);
        wait_cyc(60);
        rd_reg(0, 1, d); chk("R6 stalled status", d, 32'b101);
        chk("R6 no frame while stalled", 32'(log_n), 32'd1);
        sl_word = 32'h33;
        rd_reg(0, 3, d); chk("R6 held word", d, 32'h5C);
        wait_cyc(60);
        rd_reg(0, 1, d); chk("R6 retry completes", d, 32'd7);
        chk("R6 second frame", 32'(log_n), 32'd2);
        rd_reg(0, 3, d); chk("R6 new word", d, 32'h33);

        // R7 turbo proceeds while receive-full
        wr_reg(0, 3, 32'h22);
        wait_cyc(60);
        wr_reg(0, 0, cfgw(0, 7, 1, 0));
        wr_reg(0, 3, 32'h44);
        wait_cyc(60);
        chk("R7 turbo frame", 32'(log_n), 32'd4);
        chk("R7 turbo word", sl_cap & 32'hFF, 32'h44);

        // R9 DMA request equations
        do_reset();
        wr_reg(2, 0, 32'h0000C000 | cfgw(0, 7, 0, 0));
        chk("R9 disabled no request", {28'b0, txd}, 32'd0);
        wr_reg(2, 2, 32'd1);
        chk("R9 tx request", {24'b0, txd, rxd}, 32'h40);
        wr_reg(2, 3, 32'h99);
        wait_cyc(60);
        chk("R9 both requests", {24'b0, txd, rxd}, 32'h44);
        wr_reg(2, 0, 32'h0000C000 | cfgw(2, 7, 0, 0));
        chk("R9 tx-only masks rx", {24'b0, txd, rxd}, 32'h40);
        wr_reg(2, 0, 32'h0000C000 | cfgw(1, 7, 0, 0));
        chk("R9 rx-only masks tx", {24'b0, txd, rxd}, 32'h04);

        // R10 ascending grant order
        do_reset();
        sl_len = 8;
        for (int k = 0; k < 4; k++) wr_reg(k, 0, cfgw(0, 7, 0, 0));
        wr_reg(0, 2, 32'd1); wr_reg(1, 2, 32'd1); wr_reg(3, 2, 32'd1);
        wait_cyc(4);
        base = log_n;
        wr_reg(1, 3, 32'h01);
        wr_reg(3, 3, 32'h03);
        wr_reg(0, 3, 32'h00);
        wait_cyc(200);
        chk("R10 frames", 32'(log_n - base), 32'd3);
        chk("R10 first", 32'(log_ch[base]), 32'd1);
        chk("R10 second lowest", 32'(log_ch[base + 1]), 32'd0);
        chk("R10 third", 32'(log_ch[base + 2]), 32'd3);

        // R12 attempt during shift is held
        do_reset();
        wr_reg(0, 0, cfgw(1, 7, 1, 0));
        wr_reg(0, 2, 32'd1);
        wait_cyc(5);
        rd_reg(0, 3, d);
        wait_cyc(150);
        chk("R12 held attempt runs", 32'(log_n), 32'd2);

        // R11 receive-only runs without transmit writes
        do_reset();
        sl_word = 32'h81;
        wr_reg(0, 0, cfgw(1, 7, 0, 0));
        wr_reg(0, 2, 32'd1);
        wait_cyc(120);
        chk("R11 enable receives", 32'(log_n), 32'd1);
        rd_reg(0, 1, d); chk("R11 status", d, 32'd7);
        rd_reg(0, 3, d); chk("R11 word", d, 32'h81);
        wait_cyc(60);
        chk("R11 read restarts", 32'(log_n), 32'd2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule